// File: doc/BRIEF.md
# Pin Event Interrupt Bank

This block watches a bank of general-purpose input pins, arranged as several groups of up to eight pins, and turns selected pin activity into a single interrupt line for the whole bank. Each pin is first brought into the clock domain. Its trigger field then decides which activity counts as an event: a low level, a high level, a falling edge, a rising edge, or either edge. An event latches a pending bit for that pin.

Software reaches three word-wide registers per group through a simple single-cycle register port. A trigger word holds one 4-bit field per pin. A mask word holds one blocking bit per pin. A pending word records events, and software acknowledges them by writing ones. The bank interrupt is raised whenever any pending bit in any group is not blocked by its mask bit. The service routine reads the pending and mask words and combines them to find the active sources.

Top module: `pin_event_irq_bank`

## Requirements
- R1: Register addresses are byte addresses. The trigger word of group g is at 0x700 + 4g, its mask word at 0x900 + 4g, and its pending word at 0xA00 + 4g. Reads return the stored contents with the return data combinational on the address. Any other address, including a group index at or above the group count or an address with bits [1:0] nonzero, reads as zero and ignores writes.
- R2: After reset, every trigger field holds 0x7 (reads 0x77777777 with eight pins), every mask bit is 1 (reads 0xFF), every pending bit is 0, and the bank interrupt is 0.
- R3: Pin p uses bits [4p+3:4p] of its group's trigger word. Only bits [4p+2:4p] select the mode: 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge, 4 = both edges. Bit 4p+3 is stored and read back but has no effect.
- R4: Mode values 5, 6 and 7 never produce an event.
- R5: Each pin passes through a two-flop synchroniser, and edges are detected on the synchronised value. A pin change shows in the pending word no later than the third rising clock edge after the change.
- R6: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an event and a clearing write reach the same pending bit in the same cycle, the bit stays set. In a level mode, a cleared bit therefore sets again while the level is still active.
- R8: Pending bits record events whether or not the pin's mask bit is set.
- R9: The bank interrupt is the OR over all groups and pins of (pending AND NOT mask), registered, so it follows a mask or pending change one clock later.
- R10: In an edge mode, a pin held at a steady level after its edge produces no further event once the pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_GROUPS*PINS | Asynchronous pin levels, group g at bits [g*PINS +: PINS] |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| bank_irq_o | output | 1 | Bank summary interrupt |

## Verification
A wrong pending bit reaches the ports directly. It reads back in the pending word as soon as the register updates, and the interrupt line follows one clock later unless the pin is masked. A wrong synchroniser or edge history shows as a missing or extra pending bit within three clocks of a pin change, or as a pending bit that comes back after an acknowledge in an edge mode. A corrupted trigger or mask word is visible at once on readback, and it also changes which pin changes set pending bits and whether the interrupt rises.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    // Mode encoding held in bits [2:0] of each pin's trigger field
    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Register array selectors, address bits [11:8]
    localparam logic [3:0] ARR_TRIG = 4'h7;
    localparam logic [3:0] ARR_MASK = 4'h9;
    localparam logic [3:0] ARR_PEND = 4'hA;

    localparam int FIELD_W = 4;
    localparam logic [3:0] FIELD_RST = 4'h7;

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/evt_detect.sv
module evt_detect
    import pin_event_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [3*PINS-1:0] mode_i,
    input  logic [PINS-1:0]   cur_i,
    input  logic [PINS-1:0]   prev_i,
    output logic [PINS-1:0]   evt_o
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [2:0] m;
        assign m = mode_i[3*p +: 3];
        always_comb begin
            unique case (m)
                TRIG_LVL_LO: evt_o[p] = !cur_i[p];
                TRIG_LVL_HI: evt_o[p] = cur_i[p];
                TRIG_FALL:   evt_o[p] = prev_i[p] && !cur_i[p];
                TRIG_RISE:   evt_o[p] = !prev_i[p] && cur_i[p];
                TRIG_BOTH:   evt_o[p] = prev_i[p] ^ cur_i[p];
                default:     evt_o[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evt_group_regs.sv
module evt_group_regs
    import pin_event_pkg::*;
#(
    parameter int PINS = 8,
    localparam int CFG_W = FIELD_W * PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_we_i,
    input  logic             mask_we_i,
    input  logic             pend_we_i,
    input  logic [CFG_W-1:0] trig_wdata_i,
    input  logic [PINS-1:0]  bit_wdata_i,
    input  logic [PINS-1:0]  evt_i,
    output logic [CFG_W-1:0] trig_o,
    output logic [PINS-1:0]  mask_o,
    output logic [PINS-1:0]  pend_o
);

    logic [CFG_W-1:0] trig_q;
    logic [PINS-1:0]  mask_q;
    logic [PINS-1:0]  pend_q;
    logic [PINS-1:0]  clr;
    logic [PINS-1:0]  pend_d;

    assign clr    = pend_we_i ? bit_wdata_i : '0;
    // event takes priority over an acknowledge in the same cycle
    assign pend_d = (pend_q & ~clr) | evt_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= {PINS{FIELD_RST}};
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (trig_we_i) trig_q <= trig_wdata_i;
            if (mask_we_i) mask_q <= bit_wdata_i;
            pend_q <= pend_d;
        end
    end

    assign trig_o = trig_q;
    assign mask_o = mask_q;
    assign pend_o = pend_q;

    for (genvar p = 0; p < PINS; p++) begin : g_chk
        // R5 / R8: an event always lands in pending, masked or not
        a_r8_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[p] |=> pend_q[p]);
        // R6: acknowledge without a concurrent event clears the bit
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_we_i && bit_wdata_i[p] && !evt_i[p]) |=> !pend_q[p]);
        // R6: a zero written (or no write) keeps a set bit
        a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[p] && !(pend_we_i && bit_wdata_i[p])) |=> pend_q[p]);
        // R4: modes 5..7 are silent
        a_r4_inert_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_q[FIELD_W*p +: 3] > 3'd4) |-> !evt_i[p]);
        // R7: a pending bit only rises after an event
        a_r7_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[p]) |-> $past(evt_i[p]));
    end

endmodule

// File: rtl/pin_event_irq_bank.sv
module pin_event_irq_bank
    import pin_event_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int PINS       = 8,
    localparam int ADDR_W    = 12,
    localparam int DATA_W    = 32,
    localparam int IDX_W     = 6,
    localparam int CFG_W     = FIELD_W * PINS,
    localparam int NPIN      = NUM_GROUPS * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pins_i,
    input  logic              reg_en_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              bank_irq_o
);

    logic [3:0]       arr_sel;
    logic [IDX_W-1:0] grp_idx;
    logic             word_ok;

    assign arr_sel = reg_addr_i[11:8];
    assign grp_idx = reg_addr_i[7:2];
    assign word_ok = (reg_addr_i[1:0] == 2'b00);

    logic [CFG_W-1:0] trig_arr [NUM_GROUPS];
    logic [PINS-1:0]  mask_arr [NUM_GROUPS];
    logic [PINS-1:0]  pend_arr [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_irq;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic            hit;
        logic [PINS-1:0] cur, prev, evt;
        logic [3*PINS-1:0] mode;

        assign hit = reg_en_i && reg_we_i && word_ok && (grp_idx == IDX_W'(g));

        evt_sync #(.W(PINS)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (pins_i[g*PINS +: PINS]),
            .cur_o  (cur),
            .prev_o (prev)
        );

        for (genvar p = 0; p < PINS; p++) begin : g_mode
            assign mode[3*p +: 3] = trig_arr[g][FIELD_W*p +: 3];
        end

        evt_detect #(.PINS(PINS)) u_det (
            .mode_i (mode),
            .cur_i  (cur),
            .prev_i (prev),
            .evt_o  (evt)
        );

        evt_group_regs #(.PINS(PINS)) u_regs (
            .clk          (clk),
            .rst_n        (rst_n),
            .trig_we_i    (hit && arr_sel == ARR_TRIG),
            .mask_we_i    (hit && arr_sel == ARR_MASK),
            .pend_we_i    (hit && arr_sel == ARR_PEND),
            .trig_wdata_i (reg_wdata_i[CFG_W-1:0]),
            .bit_wdata_i  (reg_wdata_i[PINS-1:0]),
            .evt_i        (evt),
            .trig_o       (trig_arr[g]),
            .mask_o       (mask_arr[g]),
            .pend_o       (pend_arr[g])
        );

        assign grp_irq[g] = |(pend_arr[g] & ~mask_arr[g]);
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_en_i && word_ok && grp_idx == IDX_W'(g)) begin
                unique case (arr_sel)
                    ARR_TRIG: reg_rdata_o = DATA_W'(trig_arr[g]);
                    ARR_MASK: reg_rdata_o = DATA_W'(mask_arr[g]);
                    ARR_PEND: reg_rdata_o = DATA_W'(pend_arr[g]);
                    default:  reg_rdata_o = '0;
                endcase
            end
        end
    end

    logic irq_q;
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |grp_irq;
    end
    assign bank_irq_o = irq_q;

    // R9: the summary line never rises while every group was quiet
    a_r9_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(grp_irq != '0));

endmodule

// File: tb/pin_event_irq_bank_bench.sv
module pin_event_irq_bank_bench;

    localparam int G = 2;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [G*P-1:0] pins = '0;
    logic        en = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pin_event_irq_bank #(.NUM_GROUPS(G), .PINS(P)) u_pin_event_irq_bank (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .reg_en_i(en), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bank_irq_o(irq)
    );

    function automatic logic [11:0] a_trig(int g); return 12'h700 + 12'(4*g); endfunction
    function automatic logic [11:0] a_mask(int g); return 12'h900 + 12'(4*g); endfunction
    function automatic logic [11:0] a_pend(int g); return 12'hA00 + 12'(4*g); endfunction

    // expected pending bit after holding old, then moving to new (R3, R4)
    function automatic logic exp_pend(logic [2:0] m, logic o, logic n);
        case (m)
            3'd0: return !o || !n;
            3'd1: return o || n;
            3'd2: return o && !n;
            3'd3: return !o && n;
            3'd4: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic lvl_active(logic [2:0] m, logic n);
        return (m == 3'd0 && !n) || (m == 3'd1 && n);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        en = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        en = 0; we = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        en = 1; we = 0; addr = a;
        #1 d = rdata;
        en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4417));
        idle(3);
        rst_n = 1;
        idle(2);

        // R2 reset state
        rd(a_trig(0), v); chk("R2 trig reset", v, 32'h77777777);
        rd(a_mask(1), v); chk("R2 mask reset", v, 32'hFF);
        rd(a_pend(0), v); chk("R2 pend reset", v, 32'h0);
        chk("R2 irq reset", {31'b0, irq}, 32'h0);

        // R1 map, readback and unmapped addresses
        wr(a_mask(1), 32'h5A); rd(a_mask(1), v); chk("R1 mask readback", v, 32'h5A);
        wr(a_trig(1), 32'hF777777F); rd(a_trig(1), v); chk("R1 trig readback", v, 32'hF777777F);
        rd(12'h800, v); chk("R1 unmapped", v, 32'h0);
        wr(12'h708, 32'h0); rd(12'h708, v); chk("R1 group out of range", v, 32'h0);
        rd(a_trig(0), v); chk("R1 stray write ignored", v, 32'h77777777);
        wr(a_mask(1), 32'hFF); wr(a_trig(1), 32'h77777777);

        // R7 level high, event beats clear
        wr(a_trig(0), 32'h77777771);
        pins[0] = 1; idle(6);
        rd(a_pend(0), v); chk("R7 level high sets", v, 32'h01);
        wr(a_pend(0), 32'h01);
        rd(a_pend(0), v); chk("R7 event wins over clear", v, 32'h01);
        pins[0] = 0; idle(6);
        rd(a_pend(0), v); chk("R6 sticky after level gone", v, 32'h01);
        wr(a_pend(0), 32'h00); idle(1);
        rd(a_pend(0), v); chk("R6 zero write keeps", v, 32'h01);
        wr(a_pend(0), 32'h01); idle(3);
        rd(a_pend(0), v); chk("R6 one write clears", v, 32'h00);

        // R10 / R5 rising edge on pin 1, masked first (R8), then unmasked (R9)
        wr(a_trig(0), 32'h77777737);
        pins[1] = 1;
        idle(2);
        rd(a_pend(0), v); chk("R5 pend within three edges", v, 32'h02);
        idle(3);
        chk("R8 masked no irq", {31'b0, irq}, 32'h0);
        wr(a_mask(0), 32'hFD); idle(1);
        chk("R9 irq after unmask", {31'b0, irq}, 32'h1);
        wr(a_pend(0), 32'h02); idle(6);
        rd(a_pend(0), v); chk("R10 no re-event on steady level", v, 32'h00);
        chk("R9 irq drops", {31'b0, irq}, 32'h0);
        pins[1] = 0; wr(a_trig(0), 32'h77777777); wr(a_mask(0), 32'hFF);
        idle(6); wr(a_pend(0), 32'hFF);

        // random trials across groups, pins, modes (incl. bit 3 and inert codes)
        for (int it = 0; it < 60; it++) begin
            int g = int'($urandom % G);
            int p = int'($urandom % P);
            logic [3:0] m4 = 4'($urandom);
            logic o = 1'($urandom);
            logic n = 1'($urandom);
            logic mb = 1'($urandom);
            logic [31:0] cfg = 32'h77777777;
            logic e;
            cfg[4*p +: 4] = m4;
            pins[g*P+p] = o; idle(6);
            wr(a_pend(g), 32'hFF);
            wr(a_mask(g), mb ? 32'hFF : (32'hFF & ~(32'h1 << p)));
            wr(a_trig(g), cfg);
            idle(4);
            pins[g*P+p] = n; idle(6);
            e = exp_pend(m4[2:0], o, n);
            rd(a_pend(g), v);
            chk("R3 R4 random pend", v, 32'(e) << p);
            chk("R9 random irq", {31'b0, irq}, {31'b0, e && !mb});
            wr(a_pend(g), 32'h1 << p); idle(3);
            rd(a_pend(g), v);
            chk("R7 random after clear", v, 32'(lvl_active(m4[2:0], n)) << p);
            wr(a_trig(g), 32'h77777777);
            wr(a_mask(g), 32'hFF);
            wr(a_pend(g), 32'hFF);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule